// File: doc/BRIEF.md
# Configuration Boot Loader for a Byte-Wide Non-Volatile Memory

After bus reset is released, this block reads an external byte-wide non-volatile memory and decides whether it holds a valid setup image. It first reads two identification bytes. If both are blank (0xFF), the memory is treated as absent. Otherwise it reads a four-byte signature, and only when every signature byte matches does it copy a 64-byte image into the configuration register file, one byte per memory access. Until the block has either rejected the memory or finished the copy, its ready output stays low. The bus target uses that output to insert wait states on host configuration cycles.

Every memory access takes a fixed number of clocks, eight by default. The address is driven for the whole access, and the data is taken in the last clock. A strap input can bypass the memory entirely, so the configuration keeps its defaults. The block also passes bus reset through as a reset for the add-on logic.

Top module: `cfg_nv_boot`

## Requirements
- R1: `addOnRstN` is low whenever `busRstN` is low and high whenever `busRstN` is high.
- R2: While reset is held, and at release, `memAddr` is 0x0040. Each access holds its address for 8 clocks. With the strap low, access n uses 0x0040 and 0x0041 for n=0..1, 0x0050..0x0053 for n=2..5, and 0x0040+(n-6) for n=6..69. The address changes only at the clock edge that ends an access.
- R3: With `modeSel` high, `cfgReady` is high from the first clock edge after release. No write is issued and `memAddr` stays 0x0040.
- R4: If both identification bytes (0x0040, 0x0041) read 0xFF, `cfgReady` rises at edge 16 after release and no write is issued.
- R5: Otherwise the signature is checked: 0x0050 must hold 0xC0, 0xC1 or 0xC2, 0x0051 must hold 0xFF, 0x0052 must hold 0xE8 and 0x0053 must hold 0x10. On the first mismatch, at signature position k (0..3), `cfgReady` rises at edge 8*(3+k) and no write is issued.
- R6: For a valid image, exactly 64 writes are made. Each `cfgWrEn` pulse lasts one cycle, in the last clock of an access. `cfgWrIdx` counts 0..63 in order, and `cfgWrData` equals the byte at 0x0040+`cfgWrIdx`.
- R7: `cfgReady` stays low until the outcome is known. After a full load it rises at edge 560 after release.
- R8: Once high, `cfgReady` stays high until the next reset, and no write follows it.
- R9: Reset asserted at any point aborts the sequence asynchronously: ready goes low, writes stop and the address returns to 0x0040. Releasing reset restarts the whole sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| busRstN | input | 1 | Bus reset, active low, asynchronous |
| modeSel | input | 1 | Strap: low selects the byte-wide memory, high bypasses it |
| memData | input | 8 | Data bus from the memory |
| memAddr | output | 16 | Address bus to the memory |
| cfgWrEn | output | 1 | One-cycle write strobe to the configuration register file |
| cfgWrIdx | output | 6 | Byte offset of the write, 0 to 63 |
| cfgWrData | output | 8 | Byte written |
| cfgReady | output | 1 | High once loading is settled; gates target-ready for configuration cycles |
| addOnRstN | output | 1 | Reset for the add-on logic, active low |

## Verification
The bench places a mismatch at each of the four signature positions and checks that ready rises at exactly the end of the failing access. A loader that kept reading would be late, and one that wrote the image anyway would show stray writes. Mixed identification bytes such as 0xFF/0x00 must still lead to a full load, which catches a design that tests either byte instead of both. A memory that is blank but holds a good signature must still be rejected. A reset in the middle of the load must not leave ready set, and it must restart cleanly from offset 0 so that the final count is exactly 64 ascending writes.

// File: rtl/nvboot_pkg.sv
package nvboot_pkg;

  typedef enum logic [1:0] {
    ST_PROBE = 2'd0,
    ST_SIG   = 2'd1,
    ST_LOAD  = 2'd2,
    ST_DONE  = 2'd3
  } bootState_t;

  // address strobes from control to datapath
  typedef struct packed {
    logic goImg;  // jump to image base
    logic goSig;  // jump to signature base
    logic step;   // advance by one byte
  } addrCtl_t;

  localparam int SIG_LEN = 4;

  // signature byte compare; position 0 accepts three revision codes
  function automatic logic sigByteOk(input logic [1:0] pos, input logic [7:0] d);
    case (pos)
      2'd0:    sigByteOk = (d == 8'hC0) || (d == 8'hC1) || (d == 8'hC2);
      2'd1:    sigByteOk = (d == 8'hFF);
      2'd2:    sigByteOk = (d == 8'hE8);
      default: sigByteOk = (d == 8'h10);
    endcase
  endfunction

endpackage

// File: rtl/nvboot_ctrl.sv
module nvboot_ctrl
  import nvboot_pkg::*;
#(
  parameter int ACCESS_CLKS = 8,
  parameter int IMG_BYTES   = 64
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     modeSel,
  input  logic     dataIsFF,
  input  logic     sigOk,
  output addrCtl_t addrCtl,
  output logic     wrEn,
  output logic     ready
);

  localparam int CW = (ACCESS_CLKS > 1) ? $clog2(ACCESS_CLKS) : 1;
  localparam int IW = (IMG_BYTES > 1) ? $clog2(IMG_BYTES) : 1;
  localparam logic [CW-1:0] LAST_TICK = CW'(ACCESS_CLKS - 1);
  localparam logic [IW-1:0] LAST_IMG  = IW'(IMG_BYTES - 1);
  localparam logic [IW-1:0] LAST_SIG  = IW'(SIG_LEN - 1);
  localparam logic [IW-1:0] ID_SECOND = IW'(1);

  bootState_t    state;
  logic [CW-1:0] tickCnt;
  logic [IW-1:0] stepIdx;
  logic          firstFF;
  logic          lastTick;
  logic          blankId;

  assign lastTick = (tickCnt == LAST_TICK);
  assign blankId  = firstFF && dataIsFF;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_PROBE;
      tickCnt <= '0;
      stepIdx <= '0;
      firstFF <= 1'b0;
    end else begin
      case (state)
        ST_PROBE: begin
          if (modeSel) begin
            state <= ST_DONE;
          end else if (lastTick) begin
            tickCnt <= '0;
            if (stepIdx == '0) begin
              firstFF <= dataIsFF;
              stepIdx <= ID_SECOND;
            end else if (blankId) begin
              state <= ST_DONE;
            end else begin
              state   <= ST_SIG;
              stepIdx <= '0;
            end
          end else begin
            tickCnt <= tickCnt + CW'(1);
          end
        end
        ST_SIG: begin
          if (lastTick) begin
            tickCnt <= '0;
            if (!sigOk) begin
              state <= ST_DONE;
            end else if (stepIdx == LAST_SIG) begin
              state   <= ST_LOAD;
              stepIdx <= '0;
            end else begin
              stepIdx <= stepIdx + IW'(1);
            end
          end else begin
            tickCnt <= tickCnt + CW'(1);
          end
        end
        ST_LOAD: begin
          if (lastTick) begin
            tickCnt <= '0;
            if (stepIdx == LAST_IMG) state <= ST_DONE;
            else                     stepIdx <= stepIdx + IW'(1);
          end else begin
            tickCnt <= tickCnt + CW'(1);
          end
        end
        default: state <= ST_DONE;
      endcase
    end
  end

  always_comb begin
    addrCtl       = '0;
    addrCtl.step  = lastTick && (
                      (state == ST_PROBE && !modeSel && stepIdx == '0) ||
                      (state == ST_SIG   && sigOk    && stepIdx != LAST_SIG) ||
                      (state == ST_LOAD  && stepIdx != LAST_IMG));
    addrCtl.goSig = lastTick && state == ST_PROBE && !modeSel &&
                    stepIdx == ID_SECOND && !blankId;
    addrCtl.goImg = lastTick && state == ST_SIG && sigOk && stepIdx == LAST_SIG;
  end

  assign wrEn  = (state == ST_LOAD) && lastTick;
  assign ready = (state == ST_DONE);

  // R8: ready holds until reset
  assert_ready_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> ready);

  // R6: write strobe is a single-cycle pulse
  assert_wr_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !wrEn);

  // R3: strap high settles the loader on the next edge
  assert_mode_bypass_R3: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel && !ready) |=> ready);

endmodule

// File: rtl/nvboot_dpath.sv
module nvboot_dpath
  import nvboot_pkg::*;
#(
  parameter logic [15:0] IMG_BASE  = 16'h0040,
  parameter logic [15:0] SIG_BASE  = 16'h0050,
  parameter int          IMG_BYTES = 64
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  addrCtl_t                     addrCtl,
  input  logic [7:0]                   memData,
  output logic [15:0]                  memAddr,
  output logic                         dataIsFF,
  output logic                         sigOk,
  output logic [$clog2(IMG_BYTES)-1:0] wrIdx,
  output logic [7:0]                   wrData
);

  localparam int IW = $clog2(IMG_BYTES);
  localparam logic [15:0] IMG_TOP = IMG_BASE + 16'(IMG_BYTES - 1);

  logic [1:0] sigPos;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              memAddr <= IMG_BASE;
    else if (addrCtl.goImg) memAddr <= IMG_BASE;
    else if (addrCtl.goSig) memAddr <= SIG_BASE;
    else if (addrCtl.step)  memAddr <= memAddr + 16'd1;
  end

  assign sigPos   = memAddr[1:0] - SIG_BASE[1:0];
  assign dataIsFF = (memData == 8'hFF);
  assign sigOk    = sigByteOk(sigPos, memData);
  assign wrIdx    = memAddr[IW-1:0] - IMG_BASE[IW-1:0];
  assign wrData   = memData;

  // R2: address never leaves the setup window
  assert_addr_window_R2: assert property (@(posedge clk) disable iff (!rstN)
    (memAddr >= IMG_BASE) && (memAddr <= IMG_TOP));

endmodule

// File: rtl/cfg_nv_boot.sv
module cfg_nv_boot
  import nvboot_pkg::*;
#(
  parameter int          ACCESS_CLKS = 8,
  parameter int          IMG_BYTES   = 64,
  parameter logic [15:0] IMG_BASE    = 16'h0040,
  parameter logic [15:0] SIG_BASE    = 16'h0050
) (
  input  logic        clk,
  input  logic        busRstN,
  input  logic        modeSel,
  input  logic [7:0]  memData,
  output logic [15:0] memAddr,
  output logic        cfgWrEn,
  output logic [5:0]  cfgWrIdx,
  output logic [7:0]  cfgWrData,
  output logic        cfgReady,
  output logic        addOnRstN
);

  addrCtl_t addrCtl;
  logic     dataIsFF;
  logic     sigOk;

  assign addOnRstN = busRstN;

  nvboot_ctrl #(
    .ACCESS_CLKS(ACCESS_CLKS),
    .IMG_BYTES  (IMG_BYTES)
  ) uCtrl (
    .clk     (clk),
    .rstN    (busRstN),
    .modeSel (modeSel),
    .dataIsFF(dataIsFF),
    .sigOk   (sigOk),
    .addrCtl (addrCtl),
    .wrEn    (cfgWrEn),
    .ready   (cfgReady)
  );

  nvboot_dpath #(
    .IMG_BASE (IMG_BASE),
    .SIG_BASE (SIG_BASE),
    .IMG_BYTES(IMG_BYTES)
  ) uDpath (
    .clk     (clk),
    .rstN    (busRstN),
    .addrCtl (addrCtl),
    .memData (memData),
    .memAddr (memAddr),
    .dataIsFF(dataIsFF),
    .sigOk   (sigOk),
    .wrIdx   (cfgWrIdx),
    .wrData  (cfgWrData)
  );

  // R2: without a control strobe the address holds
  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!busRstN)
    !(addrCtl.step || addrCtl.goSig || addrCtl.goImg) |=> $stable(memAddr));

  // R7: a write is only issued while ready is low
  assert_wr_before_ready_R7: assert property (@(posedge clk) disable iff (!busRstN)
    cfgWrEn |-> !cfgReady);

endmodule

// File: tb/cfg_nv_boot_test.sv
module cfg_nv_boot_test;

  logic        clk = 1'b0;
  logic        busRstN;
  logic        modeSel;
  logic [7:0]  memData;
  logic [15:0] memAddr;
  logic        cfgWrEn;
  logic [5:0]  cfgWrIdx;
  logic [7:0]  cfgWrData;
  logic        cfgReady;
  logic        addOnRstN;

  always #4 clk = ~clk;  // 125 MHz

  cfg_nv_boot uut (
    .clk(clk), .busRstN(busRstN), .modeSel(modeSel), .memData(memData),
    .memAddr(memAddr), .cfgWrEn(cfgWrEn), .cfgWrIdx(cfgWrIdx),
    .cfgWrData(cfgWrData), .cfgReady(cfgReady), .addOnRstN(addOnRstN)
  );

  logic [7:0] mem [128];
  assign memData = (memAddr < 16'h0080) ? mem[memAddr[6:0]] : 8'hFF;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  localparam int FULL_LOAD = 8 * (2 + 4 + 64);
  localparam int RUN_EDGES = FULL_LOAD + 40;

  // fields: mode, id0, id1, sig0, sig1, sig2, sig3
  localparam int NVEC = 10;
  localparam logic [55:0] VEC [NVEC] = '{
    56'h01_12_34_C0_FF_E8_10,  // strap high
    56'h00_FF_FF_00_00_00_00,  // blank ids
    56'h00_12_34_C0_FF_E8_10,  // valid
    56'h00_FF_00_C1_FF_E8_10,  // valid, one id byte blank
    56'h00_00_FF_C2_FF_E8_10,  // valid, other id byte blank
    56'h00_12_34_C3_FF_E8_10,  // bad sig pos 0
    56'h00_12_34_C0_FE_E8_10,  // bad sig pos 1
    56'h00_12_34_C0_FF_E9_10,  // bad sig pos 2
    56'h00_12_34_C0_FF_E8_11,  // bad sig pos 3
    56'h00_FF_FF_C0_FF_E8_10   // blank ids, good signature
  };

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int expReadyOf(input logic [55:0] v);
    if (v[48]) return 1;
    if (v[47:40] == 8'hFF && v[39:32] == 8'hFF) return 16;
    if (!(v[31:24] == 8'hC0 || v[31:24] == 8'hC1 || v[31:24] == 8'hC2)) return 24;
    if (v[23:16] != 8'hFF) return 32;
    if (v[15:8] != 8'hE8) return 40;
    if (v[7:0] != 8'h10) return 48;
    return FULL_LOAD;
  endfunction

  function automatic logic [15:0] expAddr(input int n);
    if (n < 2) return 16'(16'h40 + n);
    if (n < 6) return 16'(16'h50 + n - 2);
    return 16'(16'h40 + n - 6);
  endfunction

  task automatic prepMem(input logic [55:0] v, input int seed);
    for (int i = 0; i < 128; i++) mem[i] = 8'((i * 37 + seed) ^ 90);
    mem[7'h40] = v[47:40]; mem[7'h41] = v[39:32];
    mem[7'h50] = v[31:24]; mem[7'h51] = v[23:16];
    mem[7'h52] = v[15:8];  mem[7'h53] = v[7:0];
  endtask

  task automatic runOne(input bit mode, input int expReady, input string tag);
    int wrCount, badWr, badAddr, firstRdy, dropped, expWr;
    @(negedge clk);
    busRstN = 1'b0;
    modeSel = mode;
    #1;
    check(addOnRstN == 1'b0, {tag, " R1 add-on reset low"}, int'(addOnRstN), 0);
    repeat (3) @(negedge clk);
    check(!cfgReady && !cfgWrEn && memAddr == 16'h40,
          {tag, " R9 reset state"}, int'({cfgReady, cfgWrEn, memAddr}), 16'h40);
    busRstN = 1'b1;
    #1;
    check(addOnRstN == 1'b1, {tag, " R1 add-on reset high"}, int'(addOnRstN), 1);
    expWr = (expReady == FULL_LOAD) ? 64 : 0;
    wrCount = 0; badWr = 0; badAddr = 0; firstRdy = -1; dropped = 0;
    for (int e = 1; e <= RUN_EDGES; e++) begin
      int t;
      t = e - 1;  // edges seen since release
      if (cfgReady && firstRdy < 0) firstRdy = t;
      if (!cfgReady && firstRdy >= 0) dropped++;
      if (!mode && t < expReady && memAddr != expAddr(t / 8)) badAddr++;
      if (mode && memAddr != 16'h40) badAddr++;
      if (cfgWrEn) begin
        if (e % 8 != 0 || wrCount > 63 || int'(cfgWrIdx) != wrCount ||
            cfgWrData != mem[7'(64 + (wrCount % 64))] || t >= expReady)
          badWr++;
        wrCount++;
      end
      @(negedge clk);
      #1;
    end
    check(firstRdy == expReady, {tag, " R7 ready edge"}, firstRdy, expReady);
    check(dropped == 0, {tag, " R8 ready sticky"}, dropped, 0);
    check(wrCount == expWr, {tag, " R6 write count"}, wrCount, expWr);
    check(badWr == 0, {tag, " R6 write index/data/timing"}, badWr, 0);
    check(badAddr == 0, {tag, " R2 address sequence"}, badAddr, 0);
  endtask

  initial begin
    busRstN = 1'b0;
    modeSel = 1'b0;
    prepMem(VEC[2], 0);
    repeat (2) @(negedge clk);
    check(memAddr == 16'h40 && !cfgReady, "R2 reset address", int'(memAddr), 16'h40);

    for (int v = 0; v < NVEC; v++) begin
      string tag;
      int er;
      er = expReadyOf(VEC[v]);
      if (VEC[v][48])            tag = $sformatf("vec%0d R3", v);
      else if (er == 16)         tag = $sformatf("vec%0d R4", v);
      else if (er < FULL_LOAD)   tag = $sformatf("vec%0d R5", v);
      else                       tag = $sformatf("vec%0d R6", v);
      prepMem(VEC[v], v * 11);
      runOne(VEC[v][48], er, tag);
    end

    // R9: reset in the middle of a load aborts and restarts
    prepMem(VEC[2], 77);
    @(negedge clk);
    busRstN = 1'b0;
    modeSel = 1'b0;
    repeat (2) @(negedge clk);
    busRstN = 1'b1;
    repeat (200) @(negedge clk);
    check(!cfgReady, "R7 ready low mid-load", int'(cfgReady), 0);
    busRstN = 1'b0;
    #1;
    check(memAddr == 16'h40 && !cfgWrEn && !cfgReady, "R9 async abort",
          int'({cfgReady, cfgWrEn, memAddr}), 16'h40);
    runOne(1'b0, FULL_LOAD, "abort-restart R9");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule